// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Directory

This block keeps the tag state of a 4-way set-associative cache with 128-byte lines and 128 sets, 64 KiB in total. The block chooses the set from the low virtual-address bits, so the directory read can start before translation finishes. One cycle later the translated 20-bit frame number arrives with a valid strobe. The block compares that frame number against every way of the selected set and reports a hit and the way that hit.

The set index is two bits wider than the page offset, so the top two index bits are virtual and may differ from the frame number. Each way therefore stores the whole frame number as its tag. On a miss the block picks a victim way. If that victim is dirty, the block first requests a writeback. It then requests a refill. Both requests carry a physical line address that the block builds from a stored tag or the translated frame, plus the index bits that lie inside the page.

Only one miss can be outstanding at a time. A flush input invalidates the whole directory, one set per cycle. The line data store, the translation buffer and the memory bus stay outside this block. They connect through plain request and acknowledge ports.

Top module: `vipt_dir`

## Requirements
- R1: After reset `ready_o` is 1, `busy_o`, `wb_req_o` and `fill_req_o` are 0, and every way of every set is invalid.
- R2: A lookup is accepted when `req_valid_i` and `ready_o` are both 1 at a clock edge. The set index is `va_i[13:7]`. In a later cycle with `xlat_valid_i` high, `resp_valid_o` goes high in that same cycle, with the result for `xlat_pfn_i`.
- R3: `resp_hit_o` is 1 only when a valid way of the indexed set holds a tag equal to all 20 bits of `xlat_pfn_i`. `resp_way_o` then gives that way's number, 0 to 3.
- R4: Two virtual addresses that differ only in bits 13:12 select different sets, even when they translate to the same frame. A line filled through one of them does not hit through the other.
- R5: On a miss the victim is the lowest-numbered invalid way of the set. If every way is valid, the victim comes from the replacement tree. The refill installs the frame number into that way.
- R6: Each set has replacement bits t0 (root), t1 (ways 0/1) and t2 (ways 2/3). When t0=0 the victim is way t1 (way 0 or way 1); when t0=1 it is way 2+t2. A hit or fill on way 0 sets t0=1,t1=1. On way 1 it sets t0=1,t1=0. On way 2 it sets t0=0,t2=1. On way 3 it sets t0=0,t2=0.
- R7: A store hit marks the way dirty. A store miss installs the line dirty. A load miss installs it clean.
- R8: A miss whose victim is valid and dirty raises `wb_req_o`, with `wb_addr_o` = {victim tag, `va_i[11:7]`, 7'b0}. The request holds until `wb_ack_i`, and `fill_req_o` stays low until the acknowledge arrives. A clean or invalid victim raises no writeback.
- R9: `fill_req_o` carries `fill_addr_o` = {`xlat_pfn_i`, `va_i[11:7]`, 7'b0} and holds until `fill_ack_i`. The line is installed on the acknowledge, and the block returns to ready in the next cycle.
- R10: `ready_o` is low from the cycle after a lookup is accepted until the result or the refill completes. `busy_o` is high from the cycle after a miss result until the cycle after `fill_ack_i`. Requests made while `ready_o` is low are ignored.
- R11: If `flush_i` is high while the block is ready, it wins over a request. `busy_o` is then high for exactly 128 cycles while one set per cycle is cleared, with no writeback. All ways end invalid and clean, and all replacement bits end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 14 | Low virtual-address bits of the lookup |
| req_store_i | input | 1 | Lookup is a store |
| ready_o | output | 1 | Block can accept a lookup or flush |
| xlat_valid_i | input | 1 | Translated frame number is valid |
| xlat_pfn_i | input | 20 | Translated physical frame number |
| resp_valid_o | output | 1 | Lookup result valid this cycle |
| resp_hit_o | output | 1 | Lookup hit |
| resp_way_o | output | 2 | Way that hit |
| busy_o | output | 1 | Miss handling or flush in progress |
| wb_req_o | output | 1 | Writeback request |
| wb_addr_o | output | 32 | Writeback physical line address |
| wb_ack_i | input | 1 | Writeback accepted |
| fill_req_o | output | 1 | Refill request |
| fill_addr_o | output | 32 | Refill physical line address |
| fill_ack_i | input | 1 | Refill data written |
| flush_i | input | 1 | Invalidate whole directory |

## Verification
The bench builds the block with its default parameters: 14 virtual bits, 7 offset bits, a 12-bit page and 20-bit frames. Random addresses are confined to a handful of sets that differ in both the in-page and the above-page index bits, and frames are drawn from a small pool. This fills sets, forces tree-chosen evictions of dirty and clean lines, and makes the same frame appear under aliased indices. Directed sequences cover a full flush followed by refilling, and the alias case in which a frame's low bits disagree with the index.

// File: rtl/vipt_dir_pkg.sv
package vipt_dir_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;
  localparam int TREE_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL,
    ST_FLUSH
  } dir_state_e;
endpackage

// File: rtl/vipt_way_match.sv
module vipt_way_match
  import vipt_dir_pkg::*;
#(
  parameter int PFN_W = 20
) (
  input  logic [NUM_WAYS-1:0][PFN_W-1:0] tags_i,
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [PFN_W-1:0]               pfn_i,
  output logic [NUM_WAYS-1:0]            hit_vec_o,
  output logic                           hit_o,
  output logic [WAY_W-1:0]               hit_way_o
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == pfn_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/vipt_repl.sv
module vipt_repl
  import vipt_dir_pkg::*;
(
  input  logic [TREE_W-1:0]   tree_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [WAY_W-1:0]    touch_way_i,
  output logic [WAY_W-1:0]    victim_o,
  output logic [TREE_W-1:0]   tree_next_o
);
  logic [WAY_W-1:0] tree_victim;

  // bit0 root, bit1 ways 0/1, bit2 ways 2/3
  assign tree_victim = tree_i[0] ? {1'b1, tree_i[2]} : {1'b0, tree_i[1]};

  always_comb begin
    victim_o = tree_victim;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) victim_o = WAY_W'(w);
  end

  always_comb begin
    tree_next_o = tree_i;
    case (touch_way_i)
      2'd0: begin tree_next_o[0] = 1'b1; tree_next_o[1] = 1'b1; end
      2'd1: begin tree_next_o[0] = 1'b1; tree_next_o[1] = 1'b0; end
      2'd2: begin tree_next_o[0] = 1'b0; tree_next_o[2] = 1'b1; end
      default: begin tree_next_o[0] = 1'b0; tree_next_o[2] = 1'b0; end
    endcase
  end
endmodule

// File: rtl/vipt_dir.sv
module vipt_dir
  import vipt_dir_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int OFF_W  = 7,
  parameter int PAGE_W = 12,
  parameter int PFN_W  = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [VA_W-1:0]         req_va_i,
  input  logic                    req_store_i,
  output logic                    ready_o,
  input  logic                    xlat_valid_i,
  input  logic [PFN_W-1:0]        xlat_pfn_i,
  output logic                    resp_valid_o,
  output logic                    resp_hit_o,
  output logic [WAY_W-1:0]        resp_way_o,
  output logic                    busy_o,
  output logic                    wb_req_o,
  output logic [PFN_W+PAGE_W-1:0] wb_addr_o,
  input  logic                    wb_ack_i,
  output logic                    fill_req_o,
  output logic [PFN_W+PAGE_W-1:0] fill_addr_o,
  input  logic                    fill_ack_i,
  input  logic                    flush_i
);
  localparam int SET_W   = VA_W - OFF_W;
  localparam int SETS    = 1 << SET_W;
  localparam int INPG_W  = PAGE_W - OFF_W;

  dir_state_e state_q;
  logic [SET_W-1:0]  idx_q;
  logic              store_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [WAY_W-1:0]  vic_way_q;
  logic [PFN_W-1:0]  vic_tag_q;
  logic [SET_W-1:0]  flush_cnt_q;

  logic [PFN_W-1:0]    tag_q   [SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] valid_q [SETS];
  logic [NUM_WAYS-1:0] dirty_q [SETS];
  logic [TREE_W-1:0]   tree_q  [SETS];

  logic [NUM_WAYS-1:0][PFN_W-1:0] set_tags;
  logic [NUM_WAYS-1:0] set_valid, set_dirty, hit_vec;
  logic                hit;
  logic [WAY_W-1:0]    hit_way, victim, touch_way;
  logic [TREE_W-1:0]   tree_next;
  logic                lookup_fire;

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) set_tags[w] = tag_q[idx_q][w];
  end
  assign set_valid = valid_q[idx_q];
  assign set_dirty = dirty_q[idx_q];

  vipt_way_match #(.PFN_W(PFN_W)) u_match (
    .tags_i    (set_tags),
    .valid_i   (set_valid),
    .pfn_i     (xlat_pfn_i),
    .hit_vec_o (hit_vec),
    .hit_o     (hit),
    .hit_way_o (hit_way)
  );

  assign touch_way = (state_q == ST_FILL) ? vic_way_q : hit_way;

  vipt_repl u_repl (
    .tree_i      (tree_q[idx_q]),
    .valid_i     (set_valid),
    .touch_way_i (touch_way),
    .victim_o    (victim),
    .tree_next_o (tree_next)
  );

  assign lookup_fire  = (state_q == ST_LOOKUP) && xlat_valid_i;
  assign ready_o      = (state_q == ST_IDLE);
  assign busy_o       = (state_q == ST_WB) || (state_q == ST_FILL) || (state_q == ST_FLUSH);
  assign resp_valid_o = lookup_fire;
  assign resp_hit_o   = lookup_fire && hit;
  assign resp_way_o   = hit_way;
  assign wb_req_o     = (state_q == ST_WB);
  assign fill_req_o   = (state_q == ST_FILL);
  // upper index bits are virtual: only in-page bits join the tag
  assign wb_addr_o    = {vic_tag_q, idx_q[INPG_W-1:0], {OFF_W{1'b0}}};
  assign fill_addr_o  = {pfn_q, idx_q[INPG_W-1:0], {OFF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      store_q     <= 1'b0;
      pfn_q       <= '0;
      vic_way_q   <= '0;
      vic_tag_q   <= '0;
      flush_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (flush_i) begin
            state_q     <= ST_FLUSH;
            flush_cnt_q <= '0;
          end else if (req_valid_i) begin
            state_q <= ST_LOOKUP;
            idx_q   <= req_va_i[VA_W-1:OFF_W];
            store_q <= req_store_i;
          end
        end
        ST_LOOKUP: begin
          if (xlat_valid_i) begin
            if (hit) begin
              state_q <= ST_IDLE;
            end else begin
              vic_way_q <= victim;
              vic_tag_q <= set_tags[victim];
              pfn_q     <= xlat_pfn_i;
              state_q   <= (set_valid[victim] && set_dirty[victim]) ? ST_WB : ST_FILL;
            end
          end
        end
        ST_WB:   if (wb_ack_i)   state_q <= ST_FILL;
        ST_FILL: if (fill_ack_i) state_q <= ST_IDLE;
        ST_FLUSH: begin
          flush_cnt_q <= flush_cnt_q + 1'b1;
          if (flush_cnt_q == SET_W'(SETS - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        tree_q[s]  <= '0;
      end
    end else begin
      if (lookup_fire && hit) begin
        tree_q[idx_q] <= tree_next;
        if (store_q) dirty_q[idx_q][hit_way] <= 1'b1;
      end
      if ((state_q == ST_FILL) && fill_ack_i) begin
        tree_q[idx_q]             <= tree_next;
        valid_q[idx_q][vic_way_q] <= 1'b1;
        dirty_q[idx_q][vic_way_q] <= store_q;
      end
      if (state_q == ST_FLUSH) begin
        valid_q[flush_cnt_q] <= '0;
        dirty_q[flush_cnt_q] <= '0;
        tree_q[flush_cnt_q]  <= '0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if ((state_q == ST_FILL) && fill_ack_i) tag_q[idx_q][vic_way_q] <= pfn_q;
  end

  assert_hit_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_fire |-> $onehot0(hit_vec));

  assert_invalid_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_fire && !hit && !(&set_valid)) |-> !set_valid[victim]);

  assert_wb_then_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && wb_ack_i) |=> (fill_req_o && !wb_req_o));

  assert_req_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_req_o && fill_req_o));

  assert_fill_addr_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_ack_i) |=> (fill_req_o && $stable(fill_addr_o)));

  assert_miss_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |=> (busy_o && !ready_o));
endmodule

// File: tb/vipt_dir_tb.sv
module vipt_dir_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [13:0] req_va_i = '0;
  logic        req_store_i = 1'b0;
  logic        ready_o;
  logic        xlat_valid_i = 1'b0;
  logic [19:0] xlat_pfn_i = '0;
  logic        resp_valid_o, resp_hit_o;
  logic [1:0]  resp_way_o;
  logic        busy_o, wb_req_o, fill_req_o;
  logic [31:0] wb_addr_o, fill_addr_o;
  logic        wb_ack_i = 1'b0;
  logic        fill_ack_i = 1'b0;
  logic        flush_i = 1'b0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit last_hit;
  bit last_wb;

  bit          m_valid [128][4];
  bit          m_dirty [128][4];
  logic [19:0] m_tag   [128][4];
  logic [2:0]  m_tree  [128];

  always #5 clk_i = ~clk_i;

  vipt_dir u_dut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] tree_victim(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [2:0] tree_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n = t;
    case (w)
      2'd0: begin n[0] = 1; n[1] = 1; end
      2'd1: begin n[0] = 1; n[1] = 0; end
      2'd2: begin n[0] = 0; n[2] = 1; end
      default: begin n[0] = 0; n[2] = 0; end
    endcase
    return n;
  endfunction

  function automatic logic [1:0] pick_victim(input int s);
    for (int w = 0; w < 4; w++) if (!m_valid[s][w]) return 2'(w);
    return tree_victim(m_tree[s]);
  endfunction

  task automatic access(input logic [13:0] va, input logic [19:0] pfn, input bit st);
    int s = int'(va[13:7]);
    bit exp_hit = 0;
    logic [1:0] exp_way = 0;
    logic [1:0] vic;
    int lat;
    for (int w = 0; w < 4; w++)
      if (m_valid[s][w] && m_tag[s][w] == pfn) begin exp_hit = 1; exp_way = 2'(w); end
    @(negedge clk_i);
    req_valid_i = 1; req_va_i = va; req_store_i = st;
    @(negedge clk_i);
    req_valid_i = 0;
    chk(ready_o == 0, "R10 ready low after accept", ready_o, 0);
    xlat_valid_i = 1; xlat_pfn_i = pfn;
    #1;
    chk(resp_valid_o == 1, "R2 resp_valid", resp_valid_o, 1);
    chk(resp_hit_o == exp_hit, "R3 hit", resp_hit_o, exp_hit);
    if (exp_hit) chk(resp_way_o == exp_way, "R3 way", resp_way_o, exp_way);
    last_hit = exp_hit;
    last_wb = 0;
    @(negedge clk_i);
    xlat_valid_i = 0;
    if (exp_hit) begin
      m_tree[s] = tree_touch(m_tree[s], exp_way);
      if (st) m_dirty[s][exp_way] = 1;
      chk(ready_o == 1 && busy_o == 0, "R10 ready after hit", {ready_o, busy_o}, 2'b10);
      return;
    end
    vic = pick_victim(s);
    chk(busy_o == 1, "R10 busy on miss", busy_o, 1);
    if (m_valid[s][vic] && m_dirty[s][vic]) begin
      last_wb = 1;
      chk(wb_req_o == 1 && fill_req_o == 0, "R8 wb first", {wb_req_o, fill_req_o}, 2'b10);
      chk(wb_addr_o == {m_tag[s][vic], va[11:7], 7'b0}, "R8 wb addr", wb_addr_o,
          {m_tag[s][vic], va[11:7], 7'b0});
      lat = $urandom % 4;
      req_valid_i = 1; req_va_i = ~va;
      for (int i = 0; i < lat; i++) begin
        @(negedge clk_i);
        chk(wb_req_o == 1 && fill_req_o == 0, "R8 wb held", {wb_req_o, fill_req_o}, 2'b10);
      end
      wb_ack_i = 1;
      @(negedge clk_i);
      wb_ack_i = 0;
    end else begin
      chk(wb_req_o == 0, "R8 no wb for clean victim", wb_req_o, 0);
    end
    chk(fill_req_o == 1 && wb_req_o == 0, "R9 fill req", {fill_req_o, wb_req_o}, 2'b10);
    chk(fill_addr_o == {pfn, va[11:7], 7'b0}, "R9 fill addr", fill_addr_o, {pfn, va[11:7], 7'b0});
    lat = $urandom % 4;
    req_valid_i = 1; req_va_i = ~va;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk_i);
      chk(fill_req_o == 1, "R9 fill held", fill_req_o, 1);
    end
    fill_ack_i = 1;
    @(negedge clk_i);
    fill_ack_i = 0;
    req_valid_i = 0;
    chk(fill_req_o == 0 && busy_o == 0 && ready_o == 1, "R10 idle after fill, busy requests ignored",
        {fill_req_o, busy_o, ready_o}, 3'b001);
    m_valid[s][vic] = 1;
    m_dirty[s][vic] = st;
    m_tag[s][vic]   = pfn;
    m_tree[s]       = tree_touch(m_tree[s], vic);
  endtask

  task automatic do_flush();
    int n = 0;
    @(negedge clk_i);
    flush_i = 1; req_valid_i = 1; req_va_i = 14'h0080;
    @(negedge clk_i);
    flush_i = 0; req_valid_i = 0;
    while (busy_o && n < 1000) begin
      n++;
      if (wb_req_o) chk(0, "R11 no wb during flush", wb_req_o, 0);
      @(negedge clk_i);
    end
    chk(n == 128, "R11 flush length", n, 128);
    chk(ready_o == 1, "R11 ready after flush", ready_o, 1);
    for (int s = 0; s < 128; s++) begin
      m_tree[s] = 0;
      for (int w = 0; w < 4; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 128; s++) begin
      m_tree[s] = 0;
      for (int w = 0; w < 4; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; end
    end
    repeat (3) @(negedge clk_i);
    chk(ready_o == 1 && busy_o == 0 && wb_req_o == 0 && fill_req_o == 0, "R1 reset outputs",
        {ready_o, busy_o, wb_req_o, fill_req_o}, 4'b1000);
    rst_ni = 1;
    @(negedge clk_i);
    chk(ready_o == 1, "R1 ready out of reset", ready_o, 1);

    // R1/R5: empty set misses, fills way 0..3 in order
    for (int i = 0; i < 4; i++) begin
      access({2'b00, 5'd3, 7'h11}, 20'h10000 + 20'(i), 1'b1);
      chk(last_hit == 0, "R1 empty set misses", last_hit, 0);
    end
    access({2'b00, 5'd3, 7'h00}, 20'h10002, 1'b0);
    chk(last_hit == 1, "R3 hit way 2", last_hit, 1);
    // R6/R8: full set, dirty tree victim evicted with writeback
    access({2'b00, 5'd3, 7'h00}, 20'h10009, 1'b0);
    chk(last_wb == 1, "R8 dirty eviction writes back", last_wb, 1);

    // R4: frame whose low bits disagree with index top bits
    access({2'b10, 5'd7, 7'h00}, 20'hABCD1, 1'b0);
    access({2'b01, 5'd7, 7'h00}, 20'hABCD1, 1'b0);
    chk(last_hit == 0, "R4 alias index misses", last_hit, 0);
    access({2'b10, 5'd7, 7'h40}, 20'hABCD1, 1'b0);
    chk(last_hit == 1, "R4 original index hits", last_hit, 1);
    access({2'b10, 5'd7, 7'h40}, 20'hABCD0, 1'b0);
    chk(last_hit == 0, "R3 full-frame compare", last_hit, 0);

    // R7: store hit dirties a clean line
    access({2'b11, 5'd9, 7'h00}, 20'h22222, 1'b0);
    access({2'b11, 5'd9, 7'h00}, 20'h22222, 1'b1);
    for (int i = 0; i < 4; i++) access({2'b11, 5'd9, 7'h00}, 20'h33330 + 20'(i), 1'b0);

    // random mix over few sets and frames
    for (int i = 0; i < 800; i++) begin
      logic [13:0] va;
      va = {2'($urandom), 5'($urandom % 3), 7'($urandom)};
      access(va, 20'h5A000 + 20'($urandom % 6), 1'($urandom));
    end

    // R11: flush clears everything, no writebacks
    do_flush();
    for (int i = 0; i < 3; i++) begin
      access({2'b00, 5'd3, 7'h00}, 20'h10000 + 20'(i), 1'b0);
      chk(last_hit == 0 && last_wb == 0, "R11 lines gone after flush", {last_hit, last_wb}, 0);
    end
    for (int i = 0; i < 200; i++)
      access({2'($urandom), 5'($urandom % 2), 7'h0}, 20'h5A000 + 20'($urandom % 5), 1'($urandom));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule